// File: doc/BRIEF.md
# Boundary-Scan Test Access Port Controller

This block is the serial test port of a memory device. A tester moves it through the standard sixteen-state controller using a mode input (`tms`) that is sampled on each rising edge of the test clock. In the IR branch the tester shifts a three-bit instruction in. In the DR branch it shifts data through whichever register that instruction selects. The selectable registers are a one-bit bypass stage, a 32-bit identification word, and a boundary register whose length is a parameter.

The boundary register loads its parallel inputs from the device ring. The tester can then move those bits onto the parallel update outputs. Two mode outputs tell the core which of two instructions is active: the one that drives the I/O ring from the update outputs, or the one that forces all device outputs to high impedance. Serial data leaves on `tdo`, which is retimed to the falling edge of the test clock. A separate enable output marks when a pad should drive `tdo`.

`rst` is a synchronous, active-high test reset. It has the same effect as entering Test-Logic-Reset.

Top module: `scan_tap`

## Requirements
- R1: With `rst` high, the controller sits in Test-Logic-Reset and the instruction register holds IDCODE (code 001). `tdo_oe`, `ring_drive` and `force_hiz` are 0, and `bsr_update_out` is all zeros. A DR scan run straight after reset returns the identification word.
- R2: Five consecutive rising edges with `tms` high reach Test-Logic-Reset from any state. The instruction register becomes IDCODE on the edge that enters that state.
- R3: Capture-IR loads the binary pattern 001 into the instruction shift stage. Instruction bits shift LSB first from `tdi` toward `tdo`. The new instruction takes effect only at Update-IR.
- R4: IDCODE (001) selects a 32-bit word that is shifted out LSB first. Bits 31..29 hold the revision parameter, bits 28..12 the part parameter, bits 11..1 the vendor parameter, and bit 0 is always 1.
- R5: BYPASS (111) and the undefined codes 011, 101 and 110 select a one-bit register. This register captures 0, so the data shifted out is the data shifted in, delayed by one bit.
- R6: EXTEST (000) selects the boundary register and drives `ring_drive` high. On Capture-DR the register loads `bsr_capture_in` (bit 0 is shifted out first). On Update-DR it copies the shifted contents onto `bsr_update_out`.
- R7: SAMPLE Z (010) selects the boundary register with the same capture, shift and update behaviour, drives `force_hiz` high, and keeps `ring_drive` low.
- R8: SAMPLE/PRELOAD (100) selects the boundary register with the same capture, shift and update behaviour, and keeps both mode outputs low.
- R9: `tdo` and `tdo_oe` change only on the falling edge of `tck`. `tdo_oe` is 1 only while the controller is in Shift-IR or Shift-DR.
- R10: An Update-DR pass under an instruction that does not select the boundary register leaves `bsr_update_out` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | Test clock |
| rst | input | 1 | Synchronous active-high test reset |
| tms | input | 1 | Mode select, sampled on rising `tck` |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out, updated on falling `tck` |
| tdo_oe | output | 1 | High while `tdo` should be driven |
| bsr_capture_in | input | BSR_LEN | Parallel ring values loaded at Capture-DR |
| bsr_update_out | output | BSR_LEN | Parallel values latched at Update-DR |
| ring_drive | output | 1 | EXTEST active |
| force_hiz | output | 1 | SAMPLE Z active |

## Verification
The bench builds the block with `BSR_LEN` = 8 and a distinctive non-zero part and vendor code. Because the boundary register is short, a full capture-shift-update pass takes only a few clocks. This lets every boundary-register instruction, every undefined code and the bypass code each run as one table row. The non-trivial ID fields make any misplaced or reversed bit of the 32-bit word visible. Directed tests check the falling-edge timing of `tdo`, and check the five-ones escape from the middle of a DR scan.

// File: rtl/scan_tap_pkg.sv
package scan_tap_pkg;

    localparam int IR_W = 3;
    localparam int ID_W = 32;

    localparam logic [IR_W-1:0] OP_EXTEST  = 3'b000;
    localparam logic [IR_W-1:0] OP_IDCODE  = 3'b001;
    localparam logic [IR_W-1:0] OP_SAMPLEZ = 3'b010;
    localparam logic [IR_W-1:0] OP_PRELOAD = 3'b100;
    localparam logic [IR_W-1:0] OP_BYPASS  = 3'b111;
    localparam logic [IR_W-1:0] IR_CAPTURE = 3'b001;

    typedef enum logic [3:0] {
        TS_RESET, TS_IDLE,
        TS_SEL_DR, TS_CAP_DR, TS_SH_DR, TS_EX1_DR, TS_PAU_DR, TS_EX2_DR, TS_UPD_DR,
        TS_SEL_IR, TS_CAP_IR, TS_SH_IR, TS_EX1_IR, TS_PAU_IR, TS_EX2_IR, TS_UPD_IR
    } tap_state_t;

    typedef enum logic [1:0] { SEL_BYP, SEL_ID, SEL_BSR } dr_sel_t;

    typedef struct packed {
        dr_sel_t sel;
        logic    ring_drive;
        logic    force_hiz;
    } ir_decode_t;

    function automatic tap_state_t tap_next(tap_state_t s, logic m);
        case (s)
            TS_RESET:  return m ? TS_RESET  : TS_IDLE;
            TS_IDLE:   return m ? TS_SEL_DR : TS_IDLE;
            TS_SEL_DR: return m ? TS_SEL_IR : TS_CAP_DR;
            TS_CAP_DR: return m ? TS_EX1_DR : TS_SH_DR;
            TS_SH_DR:  return m ? TS_EX1_DR : TS_SH_DR;
            TS_EX1_DR: return m ? TS_UPD_DR : TS_PAU_DR;
            TS_PAU_DR: return m ? TS_EX2_DR : TS_PAU_DR;
            TS_EX2_DR: return m ? TS_UPD_DR : TS_SH_DR;
            TS_UPD_DR: return m ? TS_SEL_DR : TS_IDLE;
            TS_SEL_IR: return m ? TS_RESET  : TS_CAP_IR;
            TS_CAP_IR: return m ? TS_EX1_IR : TS_SH_IR;
            TS_SH_IR:  return m ? TS_EX1_IR : TS_SH_IR;
            TS_EX1_IR: return m ? TS_UPD_IR : TS_PAU_IR;
            TS_PAU_IR: return m ? TS_EX2_IR : TS_PAU_IR;
            TS_EX2_IR: return m ? TS_UPD_IR : TS_SH_IR;
            TS_UPD_IR: return m ? TS_SEL_DR : TS_IDLE;
            default:   return TS_RESET;
        endcase
    endfunction

    function automatic ir_decode_t decode_ir(logic [IR_W-1:0] code);
        ir_decode_t d;
        d = '{sel: SEL_BYP, ring_drive: 1'b0, force_hiz: 1'b0};
        case (code)
            OP_EXTEST:  begin d.sel = SEL_BSR; d.ring_drive = 1'b1; end
            OP_SAMPLEZ: begin d.sel = SEL_BSR; d.force_hiz  = 1'b1; end
            OP_PRELOAD: d.sel = SEL_BSR;
            OP_IDCODE:  d.sel = SEL_ID;
            default:    d.sel = SEL_BYP;
        endcase
        return d;
    endfunction

    function automatic logic [ID_W-1:0] make_id(logic [2:0] rev, logic [16:0] part,
                                                logic [10:0] vendor);
        return {rev, part, vendor, 1'b1};
    endfunction

endpackage

// File: rtl/scan_tap_fsm.sv
module scan_tap_fsm
    import scan_tap_pkg::*;
(
    input  logic       tck,
    input  logic       rst,
    input  logic       tms,
    output tap_state_t state,
    output tap_state_t state_nxt
);

    always_comb state_nxt = tap_next(state, tms);

    always_ff @(posedge tck) begin
        if (rst) state <= TS_RESET;
        else     state <= state_nxt;
    end

    // run length of consecutive high mode samples, used by the check below
    logic [2:0] ones_run;
    always_ff @(posedge tck) begin
        if (rst)              ones_run <= '0;
        else if (!tms)        ones_run <= '0;
        else if (ones_run != 3'd7) ones_run <= ones_run + 3'd1;
    end

    p_five_ones_reset_r2: assert property (@(posedge tck) disable iff (rst)
        (tms && ones_run >= 3'd4) |=> (state == TS_RESET));

endmodule

// File: rtl/scan_tap_ir.sv
module scan_tap_ir
    import scan_tap_pkg::*;
(
    input  logic            tck,
    input  logic            rst,
    input  logic            tdi,
    input  tap_state_t      state,
    input  tap_state_t      state_nxt,
    output logic [IR_W-1:0] ir,
    output logic            ir_out_bit,
    output ir_decode_t      dec
);

    logic [IR_W-1:0] ir_sh;

    always_ff @(posedge tck) begin
        if (rst) begin
            ir_sh <= IR_CAPTURE;
        end else if (state == TS_CAP_IR) begin
            ir_sh <= IR_CAPTURE;
        end else if (state == TS_SH_IR) begin
            ir_sh <= {tdi, ir_sh[IR_W-1:1]};
        end
    end

    always_ff @(posedge tck) begin
        if (rst || state_nxt == TS_RESET) ir <= OP_IDCODE;
        else if (state == TS_UPD_IR)      ir <= ir_sh;
    end

    assign ir_out_bit = ir_sh[0];
    always_comb dec = decode_ir(ir);

    p_reset_idcode_r1: assert property (@(posedge tck) disable iff (rst)
        (state == TS_RESET) |-> (ir == OP_IDCODE));

    p_capture_pattern_r3: assert property (@(posedge tck) disable iff (rst)
        (state == TS_CAP_IR) |=> (ir_sh == IR_CAPTURE));

    p_ir_only_at_update_r3: assert property (@(posedge tck) disable iff (rst)
        (state != TS_UPD_IR && state_nxt != TS_RESET) |=> $stable(ir));

    p_modes_exclusive_r7: assert property (@(posedge tck) disable iff (rst)
        !(dec.ring_drive && dec.force_hiz));

endmodule

// File: rtl/scan_tap_dr.sv
module scan_tap_dr
    import scan_tap_pkg::*;
#(
    parameter int          BSR_LEN   = 107,
    parameter logic [2:0]  ID_REV    = 3'b000,
    parameter logic [16:0] ID_PART   = 17'h00A51,
    parameter logic [10:0] ID_VENDOR = 11'h034
) (
    input  logic               tck,
    input  logic               rst,
    input  logic               tdi,
    input  tap_state_t         state,
    input  dr_sel_t            sel,
    input  logic [BSR_LEN-1:0] cap_in,
    output logic [BSR_LEN-1:0] upd_out,
    output logic               dr_out_bit
);

    localparam logic [ID_W-1:0] ID_WORD = make_id(ID_REV, ID_PART, ID_VENDOR);

    logic               byp;
    logic [ID_W-1:0]    id_sh;
    logic [BSR_LEN-1:0] bsr_sh;

    wire cap_st = (state == TS_CAP_DR);
    wire sh_st  = (state == TS_SH_DR);

    always_ff @(posedge tck) begin
        if (rst) begin
            byp    <= 1'b0;
            id_sh  <= ID_WORD;
            bsr_sh <= '0;
        end else if (cap_st) begin
            byp   <= 1'b0;
            id_sh <= ID_WORD;
            if (sel == SEL_BSR) bsr_sh <= cap_in;
        end else if (sh_st) begin
            case (sel)
                SEL_ID:  id_sh  <= {tdi, id_sh[ID_W-1:1]};
                SEL_BSR: bsr_sh <= {tdi, bsr_sh[BSR_LEN-1:1]};
                default: byp    <= tdi;
            endcase
        end
    end

    always_ff @(posedge tck) begin
        if (rst)                                      upd_out <= '0;
        else if (state == TS_UPD_DR && sel == SEL_BSR) upd_out <= bsr_sh;
    end

    always_comb begin
        case (sel)
            SEL_ID:  dr_out_bit = id_sh[0];
            SEL_BSR: dr_out_bit = bsr_sh[0];
            default: dr_out_bit = byp;
        endcase
    end

    p_bypass_zero_r5: assert property (@(posedge tck) disable iff (rst)
        (state == TS_CAP_DR) |=> (byp == 1'b0));

    p_update_hold_r10: assert property (@(posedge tck) disable iff (rst)
        !(state == TS_UPD_DR && sel == SEL_BSR) |=> $stable(upd_out));

    p_id_lsb_one_r4: assert property (@(posedge tck) disable iff (rst)
        (state == TS_CAP_DR) |=> (id_sh[0] == 1'b1));

endmodule

// File: rtl/scan_tap.sv
module scan_tap
    import scan_tap_pkg::*;
#(
    parameter int          BSR_LEN   = 107,
    parameter logic [2:0]  ID_REV    = 3'b000,
    parameter logic [16:0] ID_PART   = 17'h00A51,
    parameter logic [10:0] ID_VENDOR = 11'h034
) (
    input  logic               tck,
    input  logic               rst,
    input  logic               tms,
    input  logic               tdi,
    output logic               tdo,
    output logic               tdo_oe,
    input  logic [BSR_LEN-1:0] bsr_capture_in,
    output logic [BSR_LEN-1:0] bsr_update_out,
    output logic               ring_drive,
    output logic               force_hiz
);

    tap_state_t      state, state_nxt;
    logic [IR_W-1:0] ir;
    logic            ir_bit, dr_bit;
    ir_decode_t      dec;

    scan_tap_fsm u_fsm (
        .tck(tck), .rst(rst), .tms(tms), .state(state), .state_nxt(state_nxt)
    );

    scan_tap_ir u_ir (
        .tck(tck), .rst(rst), .tdi(tdi), .state(state), .state_nxt(state_nxt),
        .ir(ir), .ir_out_bit(ir_bit), .dec(dec)
    );

    scan_tap_dr #(
        .BSR_LEN(BSR_LEN), .ID_REV(ID_REV), .ID_PART(ID_PART), .ID_VENDOR(ID_VENDOR)
    ) u_dr (
        .tck(tck), .rst(rst), .tdi(tdi), .state(state), .sel(dec.sel),
        .cap_in(bsr_capture_in), .upd_out(bsr_update_out), .dr_out_bit(dr_bit)
    );

    wire shifting = (state == TS_SH_IR) || (state == TS_SH_DR);

    // serial output retimed half a cycle after the shift edge
    always_ff @(negedge tck) begin
        if (rst) begin
            tdo    <= 1'b0;
            tdo_oe <= 1'b0;
        end else begin
            tdo    <= (state == TS_SH_IR) ? ir_bit : dr_bit;
            tdo_oe <= shifting;
        end
    end

    assign ring_drive = dec.ring_drive;
    assign force_hiz  = dec.force_hiz;

    p_oe_in_shift_r9: assert property (@(posedge tck) disable iff (rst)
        tdo_oe |-> shifting);

    p_extest_decode_r6: assert property (@(posedge tck) disable iff (rst)
        (ir == OP_EXTEST) |-> (ring_drive && dec.sel == SEL_BSR));

endmodule

// File: tb/sim_scan_tap.sv
module sim_scan_tap;

    localparam int          BSR = 8;
    localparam logic [2:0]  REV = 3'b000;
    localparam logic [16:0] PART = 17'h0A5C3;
    localparam logic [10:0] VEND = 11'h034;
    localparam logic [31:0] ID_EXP = {REV, PART, VEND, 1'b1};

    logic tck = 1'b0, rst = 1'b1, tms = 1'b1, tdi = 1'b0;
    logic tdo, tdo_oe, ring_drive, force_hiz;
    logic [BSR-1:0] cap_in = 8'hC3;
    logic [BSR-1:0] upd_out;

    int checks = 0, errors = 0, cycles = 0;
    bit done = 0;

    always #5 tck = ~tck;

    scan_tap #(.BSR_LEN(BSR), .ID_REV(REV), .ID_PART(PART), .ID_VENDOR(VEND)) u0 (
        .tck(tck), .rst(rst), .tms(tms), .tdi(tdi), .tdo(tdo), .tdo_oe(tdo_oe),
        .bsr_capture_in(cap_in), .bsr_update_out(upd_out),
        .ring_drive(ring_drive), .force_hiz(force_hiz)
    );

    typedef struct packed {
        logic [2:0]  op;
        logic [5:0]  len;
        logic [31:0] din;
        logic [31:0] dout;
        logic [7:0]  upd;
        logic        ring;
        logic        hiz;
    } vec_t;

    localparam vec_t VEC [8] = '{
        '{3'b001, 6'd32, 32'h0,  ID_EXP, 8'h00, 1'b0, 1'b0},
        '{3'b111, 6'd8,  32'hA5, 32'h4A, 8'h00, 1'b0, 1'b0},
        '{3'b011, 6'd8,  32'h3C, 32'h78, 8'h00, 1'b0, 1'b0},
        '{3'b101, 6'd8,  32'h81, 32'h02, 8'h00, 1'b0, 1'b0},
        '{3'b100, 6'd8,  32'h5A, 32'hC3, 8'h5A, 1'b0, 1'b0},
        '{3'b000, 6'd8,  32'h96, 32'hC3, 8'h96, 1'b1, 1'b0},
        '{3'b010, 6'd8,  32'h0F, 32'hC3, 8'h0F, 1'b0, 1'b1},
        '{3'b110, 6'd8,  32'hFF, 32'hFE, 8'h0F, 1'b0, 1'b0}
    };

    function automatic string req_of(logic [2:0] op);
        case (op)
            3'b001:  return "R4";
            3'b000:  return "R6";
            3'b010:  return "R7";
            3'b100:  return "R8";
            default: return "R5";
        endcase
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick(input logic m, input logic d, output logic o, output logic oe);
        o = tdo; oe = tdo_oe;
        tms = m; tdi = d;
        @(posedge tck); @(negedge tck); #1;
    endtask

    task automatic scan_ir(input logic [2:0] op, output logic [2:0] cap);
        logic o, oe;
        tick(1, 0, o, oe); tick(1, 0, o, oe); tick(0, 0, o, oe); tick(0, 0, o, oe);
        for (int i = 0; i < 3; i++) begin
            tick(i == 2, op[i], o, oe);
            cap[i] = o;
        end
        tick(1, 0, o, oe); tick(0, 0, o, oe);
    endtask

    task automatic scan_dr(input logic [31:0] din, input int len,
                           output logic [31:0] dout, output logic oe_all);
        logic o, oe;
        dout = '0; oe_all = 1'b1;
        tick(1, 0, o, oe); tick(0, 0, o, oe); tick(0, 0, o, oe);
        for (int i = 0; i < len; i++) begin
            tick(i == len - 1, din[i], o, oe);
            dout[i] = o;
            oe_all &= oe;
        end
        tick(1, 0, o, oe); tick(0, 0, o, oe);
    endtask

    initial begin
        while (!done) begin
            @(posedge tck);
            cycles++;
            if (cycles > 20000) begin
                errors++;
                $display("FAIL watchdog: actual %0d expected < 20000 cycles", cycles);
                $display("Simulation finished: %0d checks, %0d errors", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        logic [2:0]  irc;
        logic [31:0] dv;
        logic        oeall, o, oe;

        repeat (3) @(negedge tck);
        #1;
        // R1: reset state
        chk(tdo_oe == 0, "R1 oe", 32'(tdo_oe), 0);
        chk(ring_drive == 0 && force_hiz == 0, "R1 modes", {ring_drive, force_hiz}, 0);
        chk(upd_out == 0, "R1 update", 32'(upd_out), 0);
        rst = 0;
        tick(0, 0, o, oe);
        chk(oe == 0, "R9 idle oe", 32'(oe), 0);
        scan_dr(32'h0, 32, dv, oeall);
        chk(dv == ID_EXP, "R1 default IDCODE", dv, ID_EXP);
        chk(oeall == 1, "R9 oe in shift", 32'(oeall), 1);

        // table walk over all instruction codes
        foreach (VEC[k]) begin
            scan_ir(VEC[k].op, irc);
            chk(irc == 3'b001, "R3 capture", 32'(irc), 32'h1);
            chk(ring_drive == VEC[k].ring && force_hiz == VEC[k].hiz, req_of(VEC[k].op),
                {ring_drive, force_hiz}, {VEC[k].ring, VEC[k].hiz});
            scan_dr(VEC[k].din, int'(VEC[k].len), dv, oeall);
            chk(dv == VEC[k].dout, req_of(VEC[k].op), dv, VEC[k].dout);
            // R10 when no boundary register is selected
            chk(upd_out == VEC[k].upd, (VEC[k].ring | VEC[k].hiz | VEC[k].op == 3'b100)
                ? req_of(VEC[k].op) : "R10", 32'(upd_out), 32'(VEC[k].upd));
        end

        // R9: tdo moves on the falling edge only
        scan_ir(3'b111, irc);
        tick(1, 0, o, oe); tick(0, 0, o, oe); tick(0, 0, o, oe);
        chk(tdo == 0, "R9 bypass first bit", 32'(tdo), 0);
        tms = 0; tdi = 1;
        @(posedge tck); #1;
        chk(tdo == 0, "R9 held after rising edge", 32'(tdo), 0);
        @(negedge tck); #1;
        chk(tdo == 1, "R9 change after falling edge", 32'(tdo), 1);

        // R2: five highs from inside Shift-DR, with EXTEST loaded first
        tick(1, 0, o, oe); tick(1, 0, o, oe); tick(0, 0, o, oe);
        scan_ir(3'b000, irc);
        chk(ring_drive == 1, "R6 extest mode", 32'(ring_drive), 1);
        tick(1, 0, o, oe); tick(0, 0, o, oe); tick(0, 0, o, oe);
        for (int j = 0; j < 5; j++) tick(1, 0, o, oe);
        chk(ring_drive == 0 && tdo_oe == 0, "R2 reset reached",
            {ring_drive, tdo_oe}, 0);
        tick(0, 0, o, oe);
        scan_dr(32'h0, 32, dv, oeall);
        chk(dv == ID_EXP, "R2 IDCODE after escape", dv, ID_EXP);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule